// File: doc/BRIEF.md
# Serial Interrupt Frame Generator

This block sits on the peripheral side of a shared serial interrupt line and reports the peripheral's interrupt request levels to the host, one time slot per interrupt number. A small set of mailbox channels feeds it. The first channel can raise interrupt 1 and interrupt 12. Each further channel can raise the system-management request and interrupts 6, 9, 10 and 11. Requests that share a slot are OR'ed together. The host owns the start and stop frames. Between them the block drives the slots it owns during the sample clock, restores the line high during the recovery clock and lets go of it during the turnaround clock.

The length of the host's stop frame chooses the operating mode for the next cycle. In continuous mode only the host opens frames. In quiet mode the block may open a frame itself with a one-clock low pulse whenever a slot it owns has changed since it was last reported. If the host signals that it is stopping the bus clock while such a change is waiting, the block pulls the clock-run line low to get the clock back. It holds that line low for a fixed number of clocks once the clock is running again.

Both lines are open drain. Each is modelled as an input that carries the resolved line level, plus a drive enable, plus (for the serial line) a driven value.

Top module: `sirq_frame_gen`

## Requirements
- R1: After reset the block is idle, drives neither line and is in continuous mode, so a changed request does not start a frame.
- R2: Slot n carries interrupt n, and slot 2 carries the system-management request. `ch1_req` bit 0 feeds slot 1 and bit 1 feeds slot 12. Extra channel c uses `ext_req` bits 5c..5c+4 for slots 2, 6, 9, 10 and 11 in that order. All channels are OR'ed per slot. No other slot is ever driven.
- R3: Once the host's start low ends, the first clock sampled high is a gap clock. The sample clock of slot s falls 1+3s clocks after that gap clock. In that sample clock the block drives the line low if the owned request is inactive, and leaves it undriven if the request is active.
- R4: After driving low in a sample clock, the block drives the line high for exactly the next clock (recovery) and releases it in the turnaround clock.
- R5: A stop frame of exactly two low clocks selects quiet mode.
- R6: A stop frame of three or more low clocks selects continuous mode. A single low clock leaves the mode unchanged.
- R7: In quiet mode and while idle, a slot request that differs from the value last sent makes the block drive the line low for one clock, two clocks after the request input changes. The block then follows the host's start frame.
- R8: In continuous mode the block never starts a frame, even with a changed request waiting.
- R9: A frame records every owned slot's sent value, so quiet mode with no change since the last frame starts nothing.
- R10: If the clock-run line reads high while a change is waiting, the block drives clock-run low from the next clock. It keeps driving it while the clock is stopped and releases it after `CLKRUN_HOLD` clock edges counted from the edge that armed it.
- R11: With no change waiting, a high clock-run line does not make the block drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, may be stopped by the host |
| rst_n | input | 1 | Synchronous active-low reset |
| ch1_req | input | 2 | First channel requests: bit 0 interrupt 1, bit 1 interrupt 12 |
| ext_req | input | NUM_EXT*5 | Extra channels, 5 bits each: management, int 6, int 9, int 10, int 11 |
| serirq_i | input | 1 | Resolved level of the serial interrupt line |
| serirq_o | output | 1 | Value driven on the serial line when enabled |
| serirq_oe | output | 1 | Drive enable for the serial line |
| clkrun_i | input | 1 | Resolved level of the clock-run line (high: host stopping clock) |
| clkrun_oe | output | 1 | Pulls the clock-run line low when set |

## Verification
The bench builds the block with three extra channels, sixteen slots and a clock-run hold of two edges. With three extra channels, requests from several channels land on the same slot, so the OR merge is exercised. With sixteen slots, every owned slot and the unowned slots on either side of it appear in each frame. The short hold makes release observable within a few clocks of stopping and restarting the bench clock. The vector table steps through the mode changes set by the stop frame so that the kick, no-kick and unchanged-mode cases each occur with a known pending state.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
// Shared types and slot assignments for the serial interrupt frame generator.
// Assumes at least 13 slots per frame so that every owned slot exists.
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KICK,
        ST_START,
        ST_SLOT,
        ST_STOPW
    } sirq_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOV,
        PH_TURN
    } sirq_phase_e;

    // Slot numbers on the wire
    localparam int SLOT_IRQ1  = 1;
    localparam int SLOT_SMI   = 2;
    localparam int SLOT_IRQ6  = 6;
    localparam int SLOT_IRQ9  = 9;
    localparam int SLOT_IRQ10 = 10;
    localparam int SLOT_IRQ11 = 11;
    localparam int SLOT_IRQ12 = 12;

    // Bit positions inside each extra channel's request group
    localparam int EXT_BITS  = 5;
    localparam int EXT_SMI   = 0;
    localparam int EXT_IRQ6  = 1;
    localparam int EXT_IRQ9  = 2;
    localparam int EXT_IRQ10 = 3;
    localparam int EXT_IRQ11 = 4;

    // Bit positions inside the first channel's request pair
    localparam int CH1_IRQ1  = 0;
    localparam int CH1_IRQ12 = 1;

    // Stop frame low-clock counts that select a mode
    localparam logic [1:0] STOP_QUIET_LEN = 2'd2;
    localparam logic [1:0] STOP_CONT_LEN  = 2'd3;

endpackage

// File: rtl/sirq_req_map.sv
`timescale 1ns/1ps
// Maps per-channel request bits onto frame slots and registers the result.
// Channels sharing a slot are OR'ed. Assumes NUM_SLOTS > SLOT_IRQ12.
module sirq_req_map import sirq_pkg::*; #(
    parameter int NUM_EXT   = 3,
    parameter int NUM_SLOTS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  ch1_req,
    input  logic [NUM_EXT*EXT_BITS-1:0] ext_req,
    output logic [NUM_SLOTS-1:0]        slot_req_q,
    output logic [NUM_SLOTS-1:0]        owned
);

    localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);
    localparam logic [NUM_SLOTS-1:0] OWNED_MASK =
        (ONE << SLOT_IRQ1) | (ONE << SLOT_SMI) | (ONE << SLOT_IRQ6) |
        (ONE << SLOT_IRQ9) | (ONE << SLOT_IRQ10) | (ONE << SLOT_IRQ11) |
        (ONE << SLOT_IRQ12);

    logic [NUM_EXT-1:0][NUM_SLOTS-1:0] ext_vec;
    logic [NUM_SLOTS-1:0]              slot_d;

    assign owned = OWNED_MASK;

    // One slot vector per extra channel
    generate
        for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
            localparam int B = g * EXT_BITS;
            assign ext_vec[g] =
                (NUM_SLOTS'(ext_req[B + EXT_SMI])   << SLOT_SMI)   |
                (NUM_SLOTS'(ext_req[B + EXT_IRQ6])  << SLOT_IRQ6)  |
                (NUM_SLOTS'(ext_req[B + EXT_IRQ9])  << SLOT_IRQ9)  |
                (NUM_SLOTS'(ext_req[B + EXT_IRQ10]) << SLOT_IRQ10) |
                (NUM_SLOTS'(ext_req[B + EXT_IRQ11]) << SLOT_IRQ11);
        end
    endgenerate

    // Merge the first channel and all extra channels into one slot vector
    always_comb begin
        slot_d = (NUM_SLOTS'(ch1_req[CH1_IRQ1])  << SLOT_IRQ1) |
                 (NUM_SLOTS'(ch1_req[CH1_IRQ12]) << SLOT_IRQ12);
        for (int c = 0; c < NUM_EXT; c++) begin
            slot_d = slot_d | ext_vec[c];
        end
    end

    // Register request levels so frame logic sees stable values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_req_q <= '0;
        end else begin
            slot_req_q <= slot_d;
        end
    end

endmodule

// File: rtl/sirq_frame_fsm.sv
`timescale 1ns/1ps
// Frame sequencer: follows host start/stop frames, walks the slots in
// sample/recovery/turnaround order, keeps the mode chosen by the stop
// frame and starts a frame itself in quiet mode. Outputs are decoded from
// registered state only. Assumes NUM_SLOTS is at least 13.
module sirq_frame_fsm import sirq_pkg::*; #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic [NUM_SLOTS-1:0] owned,
    output logic                 drv_oe,
    output logic                 drv_o,
    output logic                 pending,
    output logic                 quiet,
    output sirq_state_e          state
);

    localparam int               SLOT_W    = $clog2(NUM_SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    sirq_state_e          state_q, state_d;
    sirq_phase_e          ph_q, ph_d;
    logic [SLOT_W-1:0]    slot_q, slot_d;
    logic [1:0]           stop_cnt_q, stop_cnt_d;
    logic                 quiet_q, quiet_d;
    logic [NUM_SLOTS-1:0] sent_q, sent_d;
    logic                 cur_owned, cur_req, cur_sent;

    assign cur_owned = owned[slot_q];
    assign cur_req   = slot_req[slot_q];
    assign cur_sent  = sent_q[slot_q];
    assign pending   = |(slot_req ^ sent_q);
    assign quiet     = quiet_q;
    assign state     = state_q;

    // Next-state logic for frame position, mode and sent snapshot
    always_comb begin
        state_d    = state_q;
        ph_d       = ph_q;
        slot_d     = slot_q;
        stop_cnt_d = stop_cnt_q;
        quiet_d    = quiet_q;
        sent_d     = sent_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!line_i) begin
                    state_d = ST_START;
                end else if (quiet_q && pending) begin
                    state_d = ST_KICK;
                end
            end
            ST_KICK: begin
                state_d = ST_START;
            end
            ST_START: begin
                if (line_i) begin
                    state_d = ST_SLOT;
                    slot_d  = '0;
                    ph_d    = PH_SAMPLE;
                end
            end
            ST_SLOT: begin
                unique case (ph_q)
                    PH_SAMPLE: begin
                        ph_d = PH_RECOV;
                        if (cur_owned) begin
                            sent_d[slot_q] = cur_req;
                        end
                    end
                    PH_RECOV: begin
                        ph_d = PH_TURN;
                    end
                    default: begin
                        ph_d = PH_SAMPLE;
                        if (slot_q == LAST_SLOT) begin
                            state_d    = ST_STOPW;
                            stop_cnt_d = '0;
                        end else begin
                            slot_d = slot_q + SLOT_W'(1);
                        end
                    end
                endcase
            end
            ST_STOPW: begin
                if (!line_i) begin
                    if (stop_cnt_q != 2'd3) begin
                        stop_cnt_d = stop_cnt_q + 2'd1;
                    end
                end else if (stop_cnt_q != 2'd0) begin
                    if (stop_cnt_q == STOP_QUIET_LEN) begin
                        quiet_d = 1'b1;
                    end else if (stop_cnt_q >= STOP_CONT_LEN) begin
                        quiet_d = 1'b0;
                    end
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ph_q       <= PH_SAMPLE;
            slot_q     <= '0;
            stop_cnt_q <= '0;
            quiet_q    <= 1'b0;
            sent_q     <= '0;
        end else begin
            state_q    <= state_d;
            ph_q       <= ph_d;
            slot_q     <= slot_d;
            stop_cnt_q <= stop_cnt_d;
            quiet_q    <= quiet_d;
            sent_q     <= sent_d;
        end
    end

    // Line drive decode: kick pulse, low sample, high recovery
    always_comb begin
        drv_oe = 1'b0;
        drv_o  = 1'b0;
        if (state_q == ST_KICK) begin
            drv_oe = 1'b1;
        end else if (state_q == ST_SLOT && cur_owned) begin
            if (ph_q == PH_SAMPLE && !cur_req) begin
                drv_oe = 1'b1;
            end else if (ph_q == PH_RECOV && !cur_sent) begin
                drv_oe = 1'b1;
                drv_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sirq_clkrun.sv
`timescale 1ns/1ps
// Clock-restart request: arms when the clock-run line reads high while a
// change is waiting, then holds the line low for HOLD clock edges. The
// armed flop keeps driving while the clock is stopped. Assumes HOLD >= 1.
module sirq_clkrun #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic pending,
    output logic drv_oe
);

    localparam int            CW       = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HOLD - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;

    assign drv_oe = armed_q;

    // Arm on a stop request with a change waiting, release after the hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!armed_q) begin
            if (line_i && pending) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end
        end else if (cnt_q == CNT_LAST) begin
            armed_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/sirq_frame_gen.sv
`timescale 1ns/1ps
// Top of the serial interrupt frame generator. Maps channel requests to
// slots, sequences frames on the shared line and requests clock restart.
// Assumes both lines are open drain with external pull-ups.
module sirq_frame_gen import sirq_pkg::*; #(
    parameter int NUM_EXT     = 3,
    parameter int NUM_SLOTS   = 16,
    parameter int CLKRUN_HOLD = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  ch1_req,
    input  logic [NUM_EXT*EXT_BITS-1:0] ext_req,
    input  logic                        serirq_i,
    output logic                        serirq_o,
    output logic                        serirq_oe,
    input  logic                        clkrun_i,
    output logic                        clkrun_oe
);

    logic [NUM_SLOTS-1:0] slot_req;
    logic [NUM_SLOTS-1:0] owned;
    logic                 fsm_pending;
    logic                 fsm_quiet;
    sirq_state_e          fsm_state;

    sirq_req_map #(
        .NUM_EXT   (NUM_EXT),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch1_req    (ch1_req),
        .ext_req    (ext_req),
        .slot_req_q (slot_req),
        .owned      (owned)
    );

    sirq_frame_fsm #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (serirq_i),
        .slot_req (slot_req),
        .owned    (owned),
        .drv_oe   (serirq_oe),
        .drv_o    (serirq_o),
        .pending  (fsm_pending),
        .quiet    (fsm_quiet),
        .state    (fsm_state)
    );

    sirq_clkrun #(
        .HOLD (CLKRUN_HOLD)
    ) u_clkrun (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (clkrun_i),
        .pending (fsm_pending),
        .drv_oe  (clkrun_oe)
    );

endmodule

// File: rtl/sirq_frame_gen_chk.sv
`timescale 1ns/1ps
// Protocol checker for the serial interrupt frame generator, bound to the
// top so it sees the line drives, the sequencer state and the mode.
module sirq_frame_gen_chk import sirq_pkg::*; (
    input logic        clk,
    input logic        rst_n,
    input logic        serirq_oe,
    input logic        serirq_o,
    input logic        clkrun_oe,
    input sirq_state_e state,
    input logic        quiet,
    input logic        pending
);

    p_recov_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT && serirq_oe && !serirq_o) |=> (serirq_oe && serirq_o));

    p_turn_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (serirq_oe && serirq_o) |=> !serirq_oe);

    p_kick_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KICK) |=> (state == ST_START));

    p_kick_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KICK) |-> quiet);

    p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !serirq_oe);

    p_mode_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(quiet) |-> ($past(state) == ST_STOPW));

    p_clkrun_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkrun_oe) |-> $past(pending));

endmodule

bind sirq_frame_gen sirq_frame_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .serirq_oe (serirq_oe),
    .serirq_o  (serirq_o),
    .clkrun_oe (clkrun_oe),
    .state     (fsm_state),
    .quiet     (fsm_quiet),
    .pending   (fsm_pending)
);

// File: tb/sirq_frame_gen_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of request patterns and stop lengths
// drives whole frames, then directed tests cover reset and clock restart.
module sirq_frame_gen_bench;

    localparam int          NUM_EXT     = 3;
    localparam int          NUM_SLOTS   = 16;
    localparam int          CLKRUN_HOLD = 2;
    localparam logic [15:0] OWNED       = 16'h1E46; // slots 1,2,6,9,10,11,12
    localparam int          NVEC        = 7;

    // {ch1_req[1:0], ext_req[14:0], stop_len[1:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {2'b00, 15'h0000, 2'd3},
        {2'b01, 15'h0001, 2'd2},
        {2'b10, 15'h0080, 2'd2},
        {2'b10, 15'h0080, 2'd1},
        {2'b11, 15'h7C02, 2'd3},
        {2'b00, 15'h0000, 2'd2},
        {2'b01, 15'h0200, 2'd3}
    };

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic [1:0]  ch1_req = '0;
    logic [14:0] ext_req = '0;
    logic        host_low = 1'b0;
    logic        host_clkrun = 1'b0;
    logic        serirq_line, serirq_o, serirq_oe;
    logic        clkrun_line, clkrun_oe;

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic        quiet_m = 1'b0;
    logic [15:0] sent_m = '0;

    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    assign serirq_line = host_low ? 1'b0 : (serirq_oe ? serirq_o : 1'b1);
    assign clkrun_line = clkrun_oe ? 1'b0 : host_clkrun;

    sirq_frame_gen #(
        .NUM_EXT     (NUM_EXT),
        .NUM_SLOTS   (NUM_SLOTS),
        .CLKRUN_HOLD (CLKRUN_HOLD)
    ) u_sirq_frame_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch1_req   (ch1_req),
        .ext_req   (ext_req),
        .serirq_i  (serirq_line),
        .serirq_o  (serirq_o),
        .serirq_oe (serirq_oe),
        .clkrun_i  (clkrun_line),
        .clkrun_oe (clkrun_oe)
    );

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [1:0] drv();
        return {serirq_oe, serirq_oe & serirq_o};
    endfunction

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Slot vector from channel inputs, written from requirement R2
    function automatic logic [15:0] slots_of(input logic [1:0] c1, input logic [14:0] e);
        logic [15:0] s;
        s = '0;
        s[1]  = c1[0];
        s[12] = c1[1];
        for (int c = 0; c < NUM_EXT; c++) begin
            s[2]  = s[2]  | e[5*c];
            s[6]  = s[6]  | e[5*c+1];
            s[9]  = s[9]  | e[5*c+2];
            s[10] = s[10] | e[5*c+3];
            s[11] = s[11] | e[5*c+4];
        end
        return s;
    endfunction

    // One table entry: new requests, optional kick, full frame, stop frame
    task automatic run_entry(input logic [18:0] v);
        logic [15:0] sv;
        bit          chg;
        int          stop_len;
        logic        drive_low;
        ch1_req  = v[18:17];
        ext_req  = v[16:2];
        stop_len = int'(v[1:0]);
        sv       = slots_of(v[18:17], v[16:2]);
        chg      = (sv != sent_m);
        step();
        chk("R7 idle before kick", drv(), 2'b00);
        step();
        if (quiet_m && chg)      chk("R7 quiet kick", drv(), 2'b10);
        else if (quiet_m)        chk("R9 no change no kick", drv(), 2'b00);
        else                     chk("R8 continuous no kick", drv(), 2'b00);
        host_low = 1'b1;
        repeat (3) step();
        step();
        host_low = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            drive_low = OWNED[s] & ~sv[s];
            step();
            chk($sformatf("R3 slot %0d sample (R2 map)", s), drv(), drive_low ? 2'b10 : 2'b00);
            step();
            chk($sformatf("R4 slot %0d recovery", s), drv(), drive_low ? 2'b11 : 2'b00);
            step();
            chk($sformatf("R4 slot %0d turnaround", s), drv(), 2'b00);
        end
        repeat (stop_len) begin
            step();
            host_low = 1'b1;
        end
        step();
        host_low = 1'b0;
        step();
        if (stop_len == 2)      quiet_m = 1'b1;  // R5
        else if (stop_len >= 3) quiet_m = 1'b0;  // R6
        sent_m = sv;                             // R9
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk("R1 reset serial drive", drv(), 2'b00);
        chk("R1 reset clkrun drive", {1'b0, clkrun_oe}, 2'b00);
        rst_n = 1'b1;
        step();
        // R1: continuous after reset, a changed request starts nothing
        ch1_req = 2'b01;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R1 no kick after reset", drv(), 2'b00);
        end
        chk("R1 clkrun idle", {1'b0, clkrun_oe}, 2'b00);

        for (int k = 0; k < NVEC; k++) begin
            run_entry(VEC[k]);
        end

        // R11: no change waiting, host stops clock, no drive
        host_clkrun = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R11 clkrun without pending", {1'b0, clkrun_oe}, 2'b00);
        end
        host_clkrun = 1'b0;
        step();

        // R10: change waiting, host stops clock
        ch1_req = 2'b00;
        step();
        host_clkrun = 1'b1;
        step();
        chk("R10 clkrun asserted", {1'b0, clkrun_oe}, 2'b01);
        host_clkrun = 1'b0;
        clk_run = 1'b0;
        #40;
        chk("R10 clkrun held while stopped", {1'b0, clkrun_oe}, 2'b01);
        clk_run = 1'b1;
        step();
        chk("R10 clkrun held after restart", {1'b0, clkrun_oe}, 2'b01);
        step();
        chk("R10 clkrun released", {1'b0, clkrun_oe}, 2'b00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule